// File: doc/BRIEF.md
# Block-Number Event Scheduler

This block sits beside a block stream and watches two things on it: the start-of-block beat and the 48-bit block sequence number (BSN) that comes with that beat. Software programs a target BSN through a small two-word register port and arms the scheduler. When the block carrying that number begins, the block raises a trigger for exactly one clock. The trigger is meant to start some other unit, such as a signal generator, on a chosen block boundary.

The same two register addresses have two roles. A write to them loads the target BSN. A read from them returns the BSN of the most recent start-of-block beat. Software therefore uses one pair of addresses both to see where the stream is and to pick a future block.

A two-state machine does the control. In state IDLE no trigger can be produced. In state ARMED every start-of-block beat is compared against the target. The transitions are:
- ARM: a write to the upper word moves the machine from any state to ARMED.
- FIRE: a beat whose BSN equals the target produces the pulse and moves ARMED to IDLE.
- MISS: a beat whose BSN is greater than the target moves ARMED to IDLE with no pulse.
- HOLD: a beat whose BSN is smaller than the target keeps the machine in ARMED.

Top module: `bsn_event_scheduler`

## Requirements
- R1: After reset, `trigger` is 0, `reg_rvalid` is 0, the scheduler is not armed, and both register reads return 0.
- R2: A write to address 0 loads the target BSN bits [31:0] from `reg_wdata`. A write to address 1 loads the target BSN bits [47:32] from `reg_wdata[15:0]`. Target bits above bit 31 take part in the match.
- R3: Only a write to address 1 arms the scheduler; a write to address 0 alone never arms it. A new write to address 1 while armed replaces the target.
- R4: While armed, `trigger` is 1 in the same cycle as the `blk_sop` beat whose `blk_bsn` equals the target, and only for that one cycle. The scheduler is then disarmed until address 1 is written again.
- R5: While armed, a `blk_sop` beat with `blk_bsn` greater than the target disarms the scheduler with no trigger. A target that is already in the past therefore never fires, even if that BSN appears again later.
- R6: The current-BSN register takes `blk_bsn` on every `blk_sop` beat and holds its value in all other cycles.
- R7: A read (`reg_rd`=1) returns its data one cycle later, with `reg_rvalid`=1 in that cycle. Address 0 returns current BSN [31:0]. Address 1 returns current BSN [47:32] in bits [15:0], with zeros above.
- R8: When a register write and a `blk_sop` beat fall in the same cycle, that beat is judged against the armed state and target from before the write. The write takes effect from the next cycle.
- R9: A `blk_bsn` value equal to the target in a cycle without `blk_sop` produces no trigger and leaves the scheduler armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_sop | input | 1 | Start-of-block beat of the stream |
| blk_bsn | input | 48 | Block sequence number; valid when `blk_sop` is 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register word address (0 = low word, 1 = high word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| trigger | output | 1 | One-cycle pulse on the matching start-of-block beat |

## Verification
Two things can happen in the same clock: a register write (which reloads or arms the target) and the start-of-block beat that the old target is compared against. The bench provokes this on purpose in three ways:
- arming on the very beat that matches;
- re-arming on the beat that fires;
- rewriting the low word on a matching beat while armed.

Each outcome is judged by a bench model that applies the beat against the pre-write state and applies the write only at the clock edge. Whether the beat fires, and whether the following beat misses or fires, shows which value the hardware used.

// File: rtl/bsn_sched_pkg.sv
package bsn_sched_pkg;

    // Control states of the scheduler
    typedef enum logic {
        SCH_IDLE  = 1'b0,
        SCH_ARMED = 1'b1
    } sch_state_e;

    // Ordering of the stream BSN relative to the target BSN
    typedef enum logic [1:0] {
        CMP_BEFORE = 2'd0,
        CMP_MATCH  = 2'd1,
        CMP_PAST   = 2'd2
    } cmp_e;

    // Register word addresses; the high word arms the scheduler
    localparam logic ADDR_LO = 1'b0;
    localparam logic ADDR_HI = 1'b1;

endpackage

// File: rtl/bsn_sched_regs.sv
module bsn_sched_regs
    import bsn_sched_pkg::*;
#(
    parameter int unsigned BSN_W  = 48,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sop,
    input  logic [BSN_W-1:0]  bsn,
    input  logic              wr,
    input  logic              rd,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [BSN_W-1:0]  target,
    output logic              arm_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int unsigned HI_W = BSN_W - DATA_W;

    logic [DATA_W-1:0] tgt_lo;
    logic [HI_W-1:0]   tgt_hi;
    logic [BSN_W-1:0]  cur_bsn;
    logic [DATA_W-1:0] hi_word;
    logic [DATA_W-1:0] rd_mux;

    // Target BSN, loaded word by word
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_lo <= '0;
            tgt_hi <= '0;
        end else if (wr) begin
            if (addr == ADDR_LO) tgt_lo <= wdata;
            else                 tgt_hi <= wdata[HI_W-1:0];
        end
    end

    assign target = {tgt_hi, tgt_lo};
    assign arm_wr = wr && (addr == ADDR_HI);

    // Live BSN captured on each start-of-block beat
    always_ff @(posedge clk) begin
        if (rst)      cur_bsn <= '0;
        else if (sop) cur_bsn <= bsn;
    end

    // Upper word of the live BSN, zero padded to the bus width
    generate
        if (HI_W < DATA_W) begin : g_pad
            assign hi_word = {{(DATA_W-HI_W){1'b0}}, cur_bsn[BSN_W-1:DATA_W]};
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata[DATA_W-1:HI_W];
        end else begin : g_nopad
            assign hi_word = cur_bsn[BSN_W-1:DATA_W];
        end
    endgenerate

    assign rd_mux = (addr == ADDR_HI) ? hi_word : cur_bsn[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            rdata  <= rd ? rd_mux : '0;
        end
    end

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        sop |=> (cur_bsn == $past(bsn)));
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !sop |=> $stable(cur_bsn));
    assert_rvalid_R7: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid);
    assert_rquiet_R7: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rvalid);

endmodule

// File: rtl/bsn_sched_cmp.sv
module bsn_sched_cmp
    import bsn_sched_pkg::*;
#(
    parameter int unsigned BSN_W = 48,
    parameter int unsigned SEG_W = 16
) (
    input  logic [BSN_W-1:0] stream_bsn,
    input  logic [BSN_W-1:0] target_bsn,
    output cmp_e             order
);
    localparam int unsigned NSEG  = (BSN_W + SEG_W - 1) / SEG_W;
    localparam int unsigned PAD_W = NSEG * SEG_W;

    logic [PAD_W-1:0] a_p;
    logic [PAD_W-1:0] b_p;
    logic [NSEG-1:0]  seg_eq;
    logic [NSEG-1:0]  seg_gt;
    logic             all_eq;
    logic             any_gt;

    assign a_p = PAD_W'(stream_bsn);
    assign b_p = PAD_W'(target_bsn);

    // Independent per-segment compares keep the carry chains short
    generate
        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            assign seg_eq[s] = a_p[s*SEG_W +: SEG_W] == b_p[s*SEG_W +: SEG_W];
            assign seg_gt[s] = a_p[s*SEG_W +: SEG_W] >  b_p[s*SEG_W +: SEG_W];
        end
    endgenerate

    // Most significant differing segment decides the order
    always_comb begin
        logic eq_acc;
        logic gt_acc;
        eq_acc = 1'b1;
        gt_acc = 1'b0;
        for (int s = NSEG - 1; s >= 0; s--) begin
            gt_acc = gt_acc | (eq_acc & seg_gt[s]);
            eq_acc = eq_acc & seg_eq[s];
        end
        all_eq = eq_acc;
        any_gt = gt_acc;
    end

    always_comb begin
        if (all_eq)      order = CMP_MATCH;
        else if (any_gt) order = CMP_PAST;
        else             order = CMP_BEFORE;
    end

endmodule

// File: rtl/bsn_sched_fsm.sv
module bsn_sched_fsm
    import bsn_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sop,
    input  cmp_e order,
    input  logic arm_wr,
    output logic trig
);
    sch_state_e state;
    sch_state_e state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= SCH_IDLE;
        else     state <= state_nxt;
    end

    // Next state: the beat is judged first, then a high-word write arms
    always_comb begin
        state_nxt = state;
        unique case (state)
            SCH_IDLE: begin
                state_nxt = SCH_IDLE;
            end
            SCH_ARMED: begin
                if (sop && (order != CMP_BEFORE)) state_nxt = SCH_IDLE;
                else                              state_nxt = SCH_ARMED;
            end
            default: state_nxt = SCH_IDLE;
        endcase
        if (arm_wr) state_nxt = SCH_ARMED;
    end

    // Output: pulse only on the matching beat of an armed scheduler
    always_comb begin
        trig = 1'b0;
        unique case (state)
            SCH_IDLE:  trig = 1'b0;
            SCH_ARMED: trig = sop && (order == CMP_MATCH);
            default:   trig = 1'b0;
        endcase
    end

    assert_arm_R3: assert property (@(posedge clk) disable iff (rst)
        arm_wr |=> (state == SCH_ARMED));
    assert_disarm_R4: assert property (@(posedge clk) disable iff (rst)
        (trig && !arm_wr) |=> (state == SCH_IDLE));
    assert_miss_R5: assert property (@(posedge clk) disable iff (rst)
        ((state == SCH_ARMED) && sop && (order == CMP_PAST) && !arm_wr)
        |=> (state == SCH_IDLE && !trig));

endmodule

// File: rtl/bsn_event_scheduler.sv
module bsn_event_scheduler
    import bsn_sched_pkg::*;
#(
    parameter int unsigned BSN_W  = 48,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_sop,
    input  logic [BSN_W-1:0]  blk_bsn,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              trigger
);
    logic [BSN_W-1:0] target;
    logic             arm_wr;
    cmp_e             order;

    bsn_sched_regs #(
        .BSN_W  (BSN_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .sop    (blk_sop),
        .bsn    (blk_bsn),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .target (target),
        .arm_wr (arm_wr),
        .rdata  (reg_rdata),
        .rvalid (reg_rvalid)
    );

    bsn_sched_cmp #(
        .BSN_W (BSN_W),
        .SEG_W (SEG_W)
    ) u_cmp (
        .stream_bsn (blk_bsn),
        .target_bsn (target),
        .order      (order)
    );

    bsn_sched_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .sop    (blk_sop),
        .order  (order),
        .arm_wr (arm_wr),
        .trig   (trigger)
    );

    assert_match_R4: assert property (@(posedge clk) disable iff (rst)
        trigger |-> (blk_sop && (blk_bsn == target)));
    assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (trigger && !arm_wr) |=> !trigger);

endmodule

// File: tb/bsn_event_scheduler_tb.sv
`timescale 1ns/1ps
module bsn_event_scheduler_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_sop = 1'b0;
    logic [47:0] blk_bsn = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        trigger;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench model
    bit          m_armed = 1'b0;
    logic [47:0] m_tgt = '0;
    logic [47:0] m_cur = '0;
    bit          pend_rd = 1'b0;
    logic [31:0] pend_val = '0;
    logic [47:0] s_bsn = '0;

    always #10 clk = ~clk;

    bsn_event_scheduler u_dut (
        .clk        (clk),
        .rst        (rst),
        .blk_sop    (blk_sop),
        .blk_bsn    (blk_bsn),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .trigger    (trigger)
    );

    function automatic logic [31:0] exp_read(input logic a, input logic [47:0] cur);
        return a ? {16'h0000, cur[47:16+16]} : cur[31:0];
    endfunction

    function automatic logic exp_trig(input bit armed, input logic sop,
                                      input logic [47:0] bsn, input logic [47:0] tgt);
        return armed && sop && (bsn == tgt);
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: drive, check combinational trigger, update model at the edge
    task automatic step(input logic sop, input logic [47:0] bsn, input logic wr,
                        input logic rd, input logic a, input logic [31:0] wd,
                        input string req);
        @(negedge clk);
        if (pend_rd) begin
            check("R7 rvalid", 48'(reg_rvalid), 48'd1);
            check("R7 rdata", 48'(reg_rdata), 48'(pend_val));
        end
        blk_sop = sop; blk_bsn = bsn; reg_wr = wr; reg_rd = rd;
        reg_addr = a; reg_wdata = wd;
        #2;
        check(req, 48'(trigger), 48'(exp_trig(m_armed, sop, bsn, m_tgt)));
        @(posedge clk);
        pend_rd = rd;
        pend_val = exp_read(a, m_cur);
        if (m_armed && sop && bsn >= m_tgt) m_armed = 1'b0;
        if (sop) m_cur = bsn;
        if (wr && !a) m_tgt[31:0] = wd;
        if (wr && a) begin
            m_tgt[47:32] = wd[15:0];
            m_armed = 1'b1;
        end
    endtask

    task automatic beat(input logic [47:0] bsn, input string req);
        step(1'b1, bsn, 1'b0, 1'b0, 1'b0, 32'h0, req);
    endtask

    task automatic arm(input logic [47:0] t, input string req);
        step(1'b0, blk_bsn, 1'b1, 1'b0, 1'b0, t[31:0], req);
        step(1'b0, blk_bsn, 1'b1, 1'b0, 1'b1, {16'h0, t[47:32]}, req);
    endtask

    task automatic rdreg(input logic a, input string req);
        step(1'b0, blk_bsn, 1'b0, 1'b1, a, 32'h0, req);
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 trigger", 48'(trigger), 48'd0);
        check("R1 rvalid", 48'(reg_rvalid), 48'd0);
        rdreg(1'b0, "R1");
        rdreg(1'b1, "R1");
        beat(48'd0, "R1 not armed");

        // R6/R7: capture and read back
        beat(48'h1234_89AB_CDEF, "R6");
        rdreg(1'b0, "R7");
        rdreg(1'b1, "R7");
        step(1'b0, 48'h0000_1111_2222, 1'b0, 1'b1, 1'b0, 32'h0, "R6 hold");
        rdreg(1'b1, "R6 hold");

        // R3: low word alone does not arm
        step(1'b0, 48'd0, 1'b1, 1'b0, 1'b0, 32'd10, "R3");
        beat(48'd9, "R3"); beat(48'd10, "R3 no arm");
        // R4: arm and fire exactly once
        arm(48'd12, "R4");
        beat(48'd11, "R4"); beat(48'd12, "R4 fire"); beat(48'd12, "R4 once");
        // R3: rewrite target while armed
        arm(48'd20, "R3"); arm(48'd22, "R3 replace");
        beat(48'd20, "R3 old target"); beat(48'd21, "R3"); beat(48'd22, "R3 new target");

        // R9: match without start-of-block
        arm(48'd30, "R9");
        step(1'b0, 48'd30, 1'b0, 1'b0, 1'b0, 32'h0, "R9 no sop");
        beat(48'd30, "R9 fire");

        // R5: target in the past
        beat(48'd40, "R5");
        arm(48'd35, "R5");
        beat(48'd41, "R5 miss"); beat(48'd35, "R5 stays off");

        // R2: upper bits take part
        arm(48'h0002_0000_0005, "R2");
        beat(48'h0000_0000_0005, "R2 low equal");
        beat(48'h0002_0000_0004, "R2");
        beat(48'h0002_0000_0005, "R2 fire");

        // R8: write and beat in the same cycle
        arm(48'd50, "R8");
        step(1'b1, 48'd50, 1'b1, 1'b0, 1'b1, 32'h0, "R8 fire and rearm");
        beat(48'd51, "R8 rearmed past");
        step(1'b0, 48'd51, 1'b1, 1'b0, 1'b0, 32'd70, "R8");
        step(1'b1, 48'd70, 1'b1, 1'b0, 1'b1, 32'h0, "R8 arm on match");
        beat(48'd71, "R8 late");
        arm(48'd80, "R8");
        step(1'b1, 48'd80, 1'b1, 1'b0, 1'b0, 32'd90, "R8 old low word");
        beat(48'd90, "R8 disarmed");

        // Random stream with scheduling, reads and collisions
        s_bsn = 48'h0000_FFFF_FFF0;
        for (int i = 0; i < 4000; i++) begin
            logic sop;
            logic wr;
            logic rd;
            logic a;
            logic [31:0] wd;
            logic [47:0] t;
            sop = ($urandom_range(0, 2) == 0);
            if (sop) s_bsn = s_bsn + 48'd1;
            wr = 1'b0; a = 1'b0; wd = '0;
            if ($urandom_range(0, 9) == 0) begin
                t = s_bsn + 48'($urandom_range(0, 14)) - 48'd3;
                wr = 1'b1;
                a = $urandom_range(0, 1) == 1;
                wd = a ? {16'h0, t[47:32]} : t[31:0];
            end
            rd = ($urandom_range(0, 4) == 0);
            if (rd && !wr) a = $urandom_range(0, 1) == 1;
            step(sop, s_bsn, wr, rd, a, wd, "R4 random");
        end
        step(1'b0, s_bsn, 1'b0, 1'b0, 1'b0, 32'h0, "R7 drain");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule